// File: doc/BRIEF.md
# Fine-Scrolling Display Address Generator

This block produces the memory word addresses that a bitplane raster display fetches, line by line, while supporting smooth horizontal and vertical scrolling. Software programs a frame base address, a per-line word skip and a pixel shift through a byte-wide register port. A timing generator supplies frame-start, line-start and fetch-slot pulses. The block answers each usable fetch slot with an address strobe and tells the pixel serializer which bit of the first word to show first.

The frame base is double-buffered: a write to it waits for the next frame start, which copies it into the live address counter. The live counter can also be read and overwritten at any moment, and such a write steers the very next fetch, which allows split-screen effects. At the end of each line the skip value, counted in words, is added to the counter, so the display can act as a window onto a wider virtual picture. A non-zero pixel shift written through the main scroll register lengthens the line by one extra fetch group. A second scroll register applies the shift without that extra group. A line-done pulse marks the final fetch of every line and can drive a horizontal interrupt.

Top module: `fine_scroll_addr_gen`

## Requirements
- R1: Addresses are 24 bits held as three byte registers per address (high = bits 23:16, middle = 15:8, low = 7:0); bit 0 of every address is always zero, so a write of an odd low byte reads back with bit 0 cleared. Register selects: 0/1/2 base high/middle/low, 3/4/5 live counter high/middle/low, 6 line skip, 7 scroll with extra fetch, 8 scroll without extra fetch; unused selects read 0.
- R2: A base write does not alter the live counter; a `frame_start` pulse loads the live counter from the base.
- R3: The live counter reads back through selects 3..5, and a counter write sets the address of the next fetch; a counter write in the same cycle as a fetch takes precedence over that fetch's advance.
- R4: Each cycle with `fetch_slot` high while words remain in the line gives `fetch_req` high in the following cycle with `fetch_addr` equal to the counter, and the counter advances by 2 bytes; cycles without a slot give no fetch.
- R5: Fetches per line depend on `res_mode`: 0 = four-plane (WORDS_4P), 1 = two-plane (WORDS_2P), 2 or 3 = monochrome (WORDS_1P).
- R6: On the edge of the last fetch of a line, the line skip times 2 bytes is added to the counter in addition to the normal step.
- R7: A non-zero value written to select 7 adds EXTRA_4P, EXTRA_2P or EXTRA_1P fetches (by `res_mode`) to each following line; a zero value adds none.
- R8: A value written to select 8 sets the pixel shift and adds no extra fetches.
- R9: `pix_shift` takes the scroll value at `line_start` and stays constant for the whole line even if the scroll register is rewritten mid-line.
- R10: `line_done` is a one-cycle pulse in the same cycle as the final `fetch_req` of a line.
- R11: A `frame_start` during a line ends that line: no further fetches occur until the next `line_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_sel | input | 4 | Register select |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data for `cpu_sel` |
| frame_start | input | 1 | Vertical blank pulse: load counter from base |
| line_start | input | 1 | Start of a display line's fetch window |
| fetch_slot | input | 1 | A memory fetch slot is available this cycle |
| res_mode | input | 2 | Display resolution mode |
| fetch_req | output | 1 | Fetch address strobe |
| fetch_addr | output | 24 | Byte address of the fetched word |
| pix_shift | output | 4 | First-pixel bit index for the serializer |
| line_done | output | 1 | Last fetch of the line issued |

## Verification
The bench builds the block with short lines (6, 5 and 3 words for the three modes, extra groups of 4, 2 and 1) so that every mode's full line, its extra-fetch variant and the end-of-line skip fit in a few dozen cycles and each address can be checked individually. Those sizes keep the last-fetch edge, the skip addition, a mid-line counter overwrite colliding with a fetch, and a frame start cutting a line short all within reach of short directed scenarios. The full-size defaults differ only in line length, which no control path depends on.

// File: rtl/fsag_pkg.sv
// Shared definitions for the fine-scrolling address generator.
// Assumes a byte-wide register port and 24-bit byte addresses.
package fsag_pkg;
    localparam int ADDR_W = 24;
    typedef logic [ADDR_W-1:0] addr_t;

    // Register selects on the byte-wide CPU port.
    typedef enum logic [3:0] {
        SEL_BASE_HI   = 4'd0,
        SEL_BASE_MID  = 4'd1,
        SEL_BASE_LO   = 4'd2,
        SEL_CNT_HI    = 4'd3,
        SEL_CNT_MID   = 4'd4,
        SEL_CNT_LO    = 4'd5,
        SEL_LINE_SKIP = 4'd6,
        SEL_SCROLL_FX = 4'd7,
        SEL_SCROLL_NX = 4'd8
    } reg_sel_e;

    // Display resolution modes.
    typedef enum logic [1:0] {
        RES_4P  = 2'd0,
        RES_2P  = 2'd1,
        RES_1P  = 2'd2,
        RES_1PB = 2'd3
    } res_e;
endpackage

// File: rtl/fsag_regs.sv
// CPU register file: double-buffered frame base, line skip, pixel scroll
// with its extra-fetch flag, counter byte write enables and the read mux.
// Assumes reads have no side effects and writes land on the clock edge.
module fsag_regs
    import fsag_pkg::*;
#(
    parameter int OFS_W   = 8,
    parameter int SHIFT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_we,
    input  logic [3:0]         cpu_sel,
    input  logic [7:0]         cpu_wdata,
    input  addr_t              cnt,
    output addr_t              base,
    output logic [OFS_W-1:0]   line_ofs,
    output logic [SHIFT_W-1:0] scroll,
    output logic               scroll_extra,
    output logic [2:0]         cnt_wr_en,
    output logic [7:0]         cpu_rdata
);

    // Holds software-written registers; base low bit is forced even.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base         <= '0;
            line_ofs     <= '0;
            scroll       <= '0;
            scroll_extra <= 1'b0;
        end else if (cpu_we) begin
            case (cpu_sel)
                SEL_BASE_HI:   base[23:16]  <= cpu_wdata;
                SEL_BASE_MID:  base[15:8]   <= cpu_wdata;
                SEL_BASE_LO:   base[7:0]    <= {cpu_wdata[7:1], 1'b0};
                SEL_LINE_SKIP: line_ofs     <= cpu_wdata[OFS_W-1:0];
                SEL_SCROLL_FX: begin
                    scroll       <= cpu_wdata[SHIFT_W-1:0];
                    scroll_extra <= 1'b1;
                end
                SEL_SCROLL_NX: begin
                    scroll       <= cpu_wdata[SHIFT_W-1:0];
                    scroll_extra <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // Decodes byte writes aimed at the live counter (bit 2 = high byte).
    always_comb begin
        cnt_wr_en[2] = cpu_we && (cpu_sel == SEL_CNT_HI);
        cnt_wr_en[1] = cpu_we && (cpu_sel == SEL_CNT_MID);
        cnt_wr_en[0] = cpu_we && (cpu_sel == SEL_CNT_LO);
    end

    // Selects the byte returned to the CPU.
    always_comb begin
        case (cpu_sel)
            SEL_BASE_HI:   cpu_rdata = base[23:16];
            SEL_BASE_MID:  cpu_rdata = base[15:8];
            SEL_BASE_LO:   cpu_rdata = base[7:0];
            SEL_CNT_HI:    cpu_rdata = cnt[23:16];
            SEL_CNT_MID:   cpu_rdata = cnt[15:8];
            SEL_CNT_LO:    cpu_rdata = cnt[7:0];
            SEL_LINE_SKIP: cpu_rdata = 8'(line_ofs);
            SEL_SCROLL_FX: cpu_rdata = 8'(scroll);
            SEL_SCROLL_NX: cpu_rdata = 8'(scroll);
            default:       cpu_rdata = 8'h00;
        endcase
    end

    AST_BASE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        base[0] == 1'b0);  // R1
    AST_ALIAS_NO_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_sel == SEL_SCROLL_NX) |=> !scroll_extra);  // R8
    AST_MAIN_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_sel == SEL_SCROLL_FX) |=> scroll_extra);  // R7

endmodule

// File: rtl/fsag_addr_ctr.sv
// Live display address counter. Priority: frame load, then CPU byte
// write, then fetch advance. Assumes the advance amount is even.
module fsag_addr_ctr
    import fsag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_load,
    input  addr_t      base,
    input  logic [2:0] wr_en,
    input  logic [7:0] wdata,
    input  logic       adv,
    input  addr_t      adv_bytes,
    output addr_t      cnt
);

    addr_t written;

    // Merges a CPU byte write into the current counter value.
    always_comb begin
        written = cnt;
        if (wr_en[2]) written[23:16] = wdata;
        if (wr_en[1]) written[15:8]  = wdata;
        if (wr_en[0]) written[7:0]   = {wdata[7:1], 1'b0};
    end

    // Updates the counter from the highest-priority source.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (frame_load) cnt <= base;
        else if (|wr_en)     cnt <= written;
        else if (adv)        cnt <= cnt + adv_bytes;
    end

    AST_CNT_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        cnt[0] == 1'b0);  // R1
    AST_FRAME_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        frame_load |=> cnt == $past(base));  // R2

endmodule

// File: rtl/fsag_line_seq.sv
// Per-line fetch sequencer: sizes the line from the mode and scroll state,
// issues one fetch per usable slot, latches the pixel shift at line start
// and flags the last fetch. Assumes line_start arrives between lines.
module fsag_line_seq
    import fsag_pkg::*;
#(
    parameter int OFS_W    = 8,
    parameter int SHIFT_W  = 4,
    parameter int WORDS_4P = 80,
    parameter int WORDS_2P = 80,
    parameter int WORDS_1P = 40,
    parameter int EXTRA_4P = 4,
    parameter int EXTRA_2P = 2,
    parameter int EXTRA_1P = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               line_start,
    input  logic               fetch_slot,
    input  logic [1:0]         res_mode,
    input  logic [SHIFT_W-1:0] scroll,
    input  logic               scroll_extra,
    input  logic [OFS_W-1:0]   line_ofs,
    input  addr_t              cnt,
    output logic               fetch_req,
    output addr_t              fetch_addr,
    output logic [SHIFT_W-1:0] pix_shift,
    output logic               line_done,
    output logic               adv,
    output addr_t              adv_bytes
);

    localparam int SUM_4P = WORDS_4P + EXTRA_4P;
    localparam int SUM_2P = WORDS_2P + EXTRA_2P;
    localparam int SUM_1P = WORDS_1P + EXTRA_1P;
    localparam int MAX_A  = (SUM_4P > SUM_2P) ? SUM_4P : SUM_2P;
    localparam int MAX_W  = (MAX_A > SUM_1P) ? MAX_A : SUM_1P;
    localparam int WL_W   = $clog2(MAX_W + 1);

    logic [WL_W-1:0] words_left;
    logic [WL_W-1:0] plain_words;
    logic [WL_W-1:0] extra_words;
    logic [WL_W-1:0] total_words;
    logic            take;
    logic            last;

    // Picks the per-line word count and extra group for the mode.
    always_comb begin
        case (res_mode)
            RES_4P: begin
                plain_words = WL_W'(WORDS_4P);
                extra_words = WL_W'(EXTRA_4P);
            end
            RES_2P: begin
                plain_words = WL_W'(WORDS_2P);
                extra_words = WL_W'(EXTRA_2P);
            end
            default: begin
                plain_words = WL_W'(WORDS_1P);
                extra_words = WL_W'(EXTRA_1P);
            end
        endcase
        total_words = plain_words
                    + ((scroll_extra && scroll != '0) ? extra_words : '0);
    end

    // Decides whether this slot is used and what the counter step is.
    always_comb begin
        take      = fetch_slot && (words_left != '0) && !line_start && !frame_start;
        last      = take && (words_left == WL_W'(1));
        adv       = take;
        adv_bytes = addr_t'(2)
                  + (last ? {{(ADDR_W-OFS_W-1){1'b0}}, line_ofs, 1'b0} : '0);
    end

    // Tracks words left in the line and latches the line's pixel shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words_left <= '0;
            pix_shift  <= '0;
        end else if (frame_start) begin
            words_left <= '0;
        end else if (line_start) begin
            words_left <= total_words;
            pix_shift  <= scroll;
        end else if (take) begin
            words_left <= words_left - 1'b1;
        end
    end

    // Registers the fetch strobe, its address and the line-done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_req  <= 1'b0;
            fetch_addr <= '0;
            line_done  <= 1'b0;
        end else begin
            fetch_req <= take;
            line_done <= last;
            if (take) fetch_addr <= cnt;
        end
    end

    AST_FETCH_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> $past(fetch_slot));  // R4
    AST_DONE_WITH_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> fetch_req);  // R10
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> !line_done);  // R10
    AST_SHIFT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> $stable(pix_shift));  // R9
    AST_FRAME_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !fetch_req);  // R11

endmodule

// File: rtl/fine_scroll_addr_gen.sv
// Top of the fine-scrolling display address generator: ties the register
// file, the live address counter and the per-line fetch sequencer.
// Assumes timing pulses are one cycle wide and synchronous to clk.
module fine_scroll_addr_gen
    import fsag_pkg::*;
#(
    parameter int OFS_W    = 8,
    parameter int SHIFT_W  = 4,
    parameter int WORDS_4P = 80,
    parameter int WORDS_2P = 80,
    parameter int WORDS_1P = 40,
    parameter int EXTRA_4P = 4,
    parameter int EXTRA_2P = 2,
    parameter int EXTRA_1P = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cpu_we,
    input  logic [3:0]   cpu_sel,
    input  logic [7:0]   cpu_wdata,
    output logic [7:0]   cpu_rdata,
    input  logic         frame_start,
    input  logic         line_start,
    input  logic         fetch_slot,
    input  logic [1:0]   res_mode,
    output logic         fetch_req,
    output logic [23:0]  fetch_addr,
    output logic [3:0]   pix_shift,
    output logic         line_done
);

    addr_t               base;
    addr_t               cnt;
    addr_t               adv_bytes;
    logic [OFS_W-1:0]    line_ofs;
    logic [SHIFT_W-1:0]  scroll;
    logic [SHIFT_W-1:0]  shift_q;
    logic                scroll_extra;
    logic [2:0]          cnt_wr_en;
    logic                adv;

    fsag_regs #(.OFS_W(OFS_W), .SHIFT_W(SHIFT_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_we       (cpu_we),
        .cpu_sel      (cpu_sel),
        .cpu_wdata    (cpu_wdata),
        .cnt          (cnt),
        .base         (base),
        .line_ofs     (line_ofs),
        .scroll       (scroll),
        .scroll_extra (scroll_extra),
        .cnt_wr_en    (cnt_wr_en),
        .cpu_rdata    (cpu_rdata)
    );

    fsag_addr_ctr u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_load (frame_start),
        .base       (base),
        .wr_en      (cnt_wr_en),
        .wdata      (cpu_wdata),
        .adv        (adv),
        .adv_bytes  (adv_bytes),
        .cnt        (cnt)
    );

    fsag_line_seq #(
        .OFS_W    (OFS_W),
        .SHIFT_W  (SHIFT_W),
        .WORDS_4P (WORDS_4P),
        .WORDS_2P (WORDS_2P),
        .WORDS_1P (WORDS_1P),
        .EXTRA_4P (EXTRA_4P),
        .EXTRA_2P (EXTRA_2P),
        .EXTRA_1P (EXTRA_1P)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .line_start   (line_start),
        .fetch_slot   (fetch_slot),
        .res_mode     (res_mode),
        .scroll       (scroll),
        .scroll_extra (scroll_extra),
        .line_ofs     (line_ofs),
        .cnt          (cnt),
        .fetch_req    (fetch_req),
        .fetch_addr   (fetch_addr),
        .pix_shift    (shift_q),
        .line_done    (line_done),
        .adv          (adv),
        .adv_bytes    (adv_bytes)
    );

    // Presents the latched shift on the 4-bit serializer port.
    always_comb pix_shift = 4'(shift_q);

    AST_ADDR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> fetch_addr[0] == 1'b0);  // R1

endmodule

// File: tb/tb_fine_scroll_addr_gen.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_fine_scroll_addr_gen;
    localparam int CLK_PERIOD = 10;
    localparam int W4 = 6, W2 = 5, W1 = 3;
    localparam int E4 = 4, E2 = 2, E1 = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_we = 1'b0;
    logic [3:0]  cpu_sel = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        frame_start = 1'b0;
    logic        line_start = 1'b0;
    logic        fetch_slot = 1'b0;
    logic [1:0]  res_mode = 2'd0;
    logic        fetch_req;
    logic [23:0] fetch_addr;
    logic [3:0]  pix_shift;
    logic        line_done;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [23:0] exp_cnt = '0;
    int ofs_cur = 0;

    fine_scroll_addr_gen #(
        .WORDS_4P(W4), .WORDS_2P(W2), .WORDS_1P(W1),
        .EXTRA_4P(E4), .EXTRA_2P(E2), .EXTRA_1P(E1)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_sel(cpu_sel),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .frame_start(frame_start), .line_start(line_start),
        .fetch_slot(fetch_slot), .res_mode(res_mode),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .pix_shift(pix_shift), .line_done(line_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 20000)", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [3:0] sel, input logic [7:0] d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_sel = sel; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic read_reg(input logic [3:0] sel, output logic [7:0] d);
        cpu_sel = sel;
        #1;
        d = cpu_rdata;
    endtask

    task automatic read_cnt(output logic [23:0] v);
        logic [7:0] h, m, l;
        read_reg(4'd3, h); read_reg(4'd4, m); read_reg(4'd5, l);
        v = {h, m, l};
    endtask

    task automatic pulse_frame();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
    endtask

    task automatic begin_line();
        @(negedge clk); line_start = 1'b1;
        @(negedge clk); line_start = 1'b0;
    endtask

    // Runs n back-to-back slots from the line start and checks each fetch.
    task automatic run_fetches(input int n, input int first, input int total,
                               input logic [3:0] shift, input string req);
        for (int i = first; i < first + n; i++) begin
            fetch_slot = 1'b1;
            @(negedge clk);
            check(fetch_req === 1'b1, {req, " fetch strobe"}, 32'(fetch_req), 1);
            check(fetch_addr === exp_cnt, {req, " fetch address"}, 32'(fetch_addr), 32'(exp_cnt));
            check(line_done === (i == total - 1), "R10 line_done position", 32'(line_done), 32'(i == total - 1));
            check(pix_shift === shift, "R9 pix_shift held", 32'(pix_shift), 32'(shift));
            exp_cnt = exp_cnt + 24'd2;
            if (i == total - 1) exp_cnt = exp_cnt + 24'(ofs_cur * 2);
        end
        fetch_slot = 1'b0;
    endtask

    // Whole line: n fetches, then one spare slot that must not fetch.
    task automatic do_line(input int n, input logic [3:0] shift, input string req);
        logic [23:0] c;
        begin_line();
        run_fetches(n, 0, n, shift, req);
        fetch_slot = 1'b1;
        @(negedge clk);
        check(fetch_req === 1'b0, {req, " no fetch past line length"}, 32'(fetch_req), 0);
        fetch_slot = 1'b0;
        read_cnt(c);
        check(c === exp_cnt, "R6 counter after line skip", 32'(c), 32'(exp_cnt));
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int s = 0; s < 9; s++) begin
            read_reg(4'(s), d);
            check(d === 8'h00, "R1 register reset value", 32'(d), 0);
        end
        check(fetch_req === 1'b0, "R4 fetch_req reset", 32'(fetch_req), 0);
        check(line_done === 1'b0, "R10 line_done reset", 32'(line_done), 0);
        check(pix_shift === 4'd0, "R9 pix_shift reset", 32'(pix_shift), 0);
    endtask

    task automatic t_base_buffer();
        logic [7:0] d;
        logic [23:0] c;
        write_reg(4'd0, 8'h12);
        write_reg(4'd1, 8'h34);
        write_reg(4'd2, 8'h57);
        read_reg(4'd2, d);
        check(d === 8'h56, "R1 base low bit forced even", 32'(d), 32'h56);
        read_cnt(c);
        check(c === 24'h0, "R2 base write leaves counter", 32'(c), 0);
        pulse_frame();
        exp_cnt = 24'h123456;
        read_cnt(c);
        check(c === exp_cnt, "R2 frame start loads counter", 32'(c), 32'(exp_cnt));
    endtask

    task automatic t_plain_line();
        res_mode = 2'd0;
        write_reg(4'd6, 8'h10); ofs_cur = 16;
        write_reg(4'd7, 8'h00);
        do_line(W4, 4'd0, "R5 four-plane plain");
    endtask

    task automatic t_scroll_extra();
        res_mode = 2'd0;
        write_reg(4'd7, 8'h05);
        do_line(W4 + E4, 4'd5, "R7 four-plane extra");
        res_mode = 2'd1;
        write_reg(4'd7, 8'h03);
        do_line(W2 + E2, 4'd3, "R7 two-plane extra");
        res_mode = 2'd2;
        do_line(W1 + E1, 4'd3, "R7 mono extra");
    endtask

    task automatic t_alias();
        res_mode = 2'd0;
        write_reg(4'd8, 8'h09);
        do_line(W4, 4'd9, "R8 alias no extra");
    endtask

    task automatic t_modes();
        write_reg(4'd7, 8'h00);
        write_reg(4'd6, 8'h00); ofs_cur = 0;
        res_mode = 2'd1;
        do_line(W2, 4'd0, "R5 two-plane plain");
        res_mode = 2'd3;
        do_line(W1, 4'd0, "R5 mode 3 as mono");
    endtask

    task automatic t_shift_const();
        res_mode = 2'd0;
        write_reg(4'd6, 8'h03); ofs_cur = 3;
        write_reg(4'd7, 8'h06);
        begin_line();
        run_fetches(3, 0, W4 + E4, 4'd6, "R9 shift before rewrite");
        cpu_we = 1'b1; cpu_sel = 4'd8; cpu_wdata = 8'h00;
        @(negedge clk);
        cpu_we = 1'b0;
        run_fetches(W4 + E4 - 3, 3, W4 + E4, 4'd6, "R9 shift after rewrite");
    endtask

    task automatic t_cnt_write();
        logic [23:0] c;
        res_mode = 2'd0;
        write_reg(4'd8, 8'h00);
        write_reg(4'd6, 8'h02); ofs_cur = 2;
        begin_line();
        run_fetches(2, 0, W4, 4'd0, "R3 before write");
        cpu_we = 1'b1; cpu_sel = 4'd4; cpu_wdata = 8'h77;
        @(negedge clk);
        cpu_we = 1'b0;
        exp_cnt = (exp_cnt & 24'hFF00FF) | 24'h007700;
        check(fetch_req === 1'b0, "R4 no slot no fetch", 32'(fetch_req), 0);
        cpu_we = 1'b1; cpu_sel = 4'd5; cpu_wdata = 8'h21; fetch_slot = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0; fetch_slot = 1'b0;
        check(fetch_req === 1'b1 && fetch_addr === exp_cnt, "R3 fetch uses written counter",
              32'(fetch_addr), 32'(exp_cnt));
        exp_cnt = (exp_cnt & 24'hFFFF00) | 24'h000020;
        read_cnt(c);
        check(c === exp_cnt, "R3 write wins over advance", 32'(c), 32'(exp_cnt));
        run_fetches(W4 - 3, 3, W4, 4'd0, "R3 after write");
    endtask

    task automatic t_gaps();
        res_mode = 2'd2;
        write_reg(4'd8, 8'h00);
        begin_line();
        for (int i = 0; i < 6; i++) begin
            fetch_slot = (i % 2 == 0);
            @(negedge clk);
            check(fetch_req === (i % 2 == 0), "R4 fetch follows slot", 32'(fetch_req), 32'(i % 2 == 0));
            if (i % 2 == 0) begin
                check(fetch_addr === exp_cnt, "R4 gapped address", 32'(fetch_addr), 32'(exp_cnt));
                exp_cnt = exp_cnt + 24'd2;
                if (i == 4) exp_cnt = exp_cnt + 24'(ofs_cur * 2);
            end
        end
        fetch_slot = 1'b0;
    endtask

    task automatic t_abort();
        logic [23:0] c;
        res_mode = 2'd0;
        begin_line();
        run_fetches(2, 0, W4, 4'd0, "R11 before frame");
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        exp_cnt = 24'h123456;
        for (int i = 0; i < 3; i++) begin
            fetch_slot = 1'b1;
            @(negedge clk);
            check(fetch_req === 1'b0, "R11 no fetch after frame start", 32'(fetch_req), 0);
        end
        fetch_slot = 1'b0;
        read_cnt(c);
        check(c === exp_cnt, "R11 counter reloaded", 32'(c), 32'(exp_cnt));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_base_buffer();
        t_plain_line();
        t_scroll_extra();
        t_alias();
        t_modes();
        t_shift_const();
        t_cnt_write();
        t_gaps();
        t_abort();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule